// File: doc/BRIEF.md
# Sequential Wide Multiplier Built on One Byte Multiplier

This block forms the full unsigned product of two 16-bit operands using a single 8x8 unsigned multiply unit. The unit is used four times, once per pass. Each pass multiplies one byte of the first operand by one byte of the second operand. The partial product is then merged into a 32-bit result that is kept as four byte registers.

The passes always run in the same order. The first pass handles the two low bytes and writes its product into the lower half of the result. The second pass handles the two high bytes and writes its product into the upper half. The two mixed-byte products come third and fourth. Each of them is added in at a one-byte offset, and its carry ripples up into the top byte.

A user pulses `start` with both operands present. The block copies the operands on that edge and raises `busy` for four cycles. It then pulses `done` for one cycle, and from that cycle the full product is on `result`.

Top module: `wide_mul_seq`

## Requirements
- R1: In the cycle where `done` is high, `result` equals the unsigned product of the `op_a` and `op_b` values sampled with the accepted `start`.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next cycle for exactly four consecutive cycles.
- R3: `done` is high for exactly one cycle, namely the first cycle after `busy` falls. `done` and `busy` are never high together.
- R4: Changes on `op_a` and `op_b` after the accepted `start` have no effect on the product that is reported.
- R5: A `start` sampled while `busy` is high is ignored. The operation in progress completes after its four busy cycles with its own product, and no further operation follows it.
- R6: While `busy` is low, `result` keeps its value. In particular, the product stays on `result` after `done` falls, until the next operation.
- R7: After reset, `busy` is 0, `done` is 0 and `result` is 0.
- R8: No carry ever leaves the top result byte. The all-ones operands give 0xFFFE0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a product; accepted only while idle |
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| busy | output | 1 | High during the four multiply passes |
| done | output | 1 | One-cycle pulse when the product is ready |
| result | output | 32 | Full unsigned product, held until the next operation |

## Verification
Several kinds of operands are used, and each kind exercises a different part of the design:
- Zero operands and operands with one byte set show whether each partial product lands at the correct byte offset. A single byte in the wrong place changes the result.
- All-ones operands force the longest carry ripple from byte one through to the top byte. This also shows whether a carry out of the top byte is wrongly kept.
- A long series of pseudo-random operands covers the general mix of carries.
- During some runs the operands are scrambled and a second start is pulsed while the block is busy. This separates a design that captures its operands and ignores the extra start from one that reads the live inputs or restarts.

// File: rtl/wide_mul_seq_pkg.sv
package wide_mul_seq_pkg;
   localparam int NUM_PASSES = 4;

   typedef enum logic [1:0] {
      PASS_LL = 2'd0,
      PASS_HH = 2'd1,
      PASS_LH = 2'd2,
      PASS_HL = 2'd3
   } pass_e;
endpackage

// File: rtl/byte_mul.sv
module byte_mul #(
   parameter int HALF_W = 8,
   parameter int ARCH   = 0,
   localparam int PROD_W = 2 * HALF_W
) (
   input  logic [HALF_W-1:0] mul_x,
   input  logic [HALF_W-1:0] mul_y,
   output logic [PROD_W-1:0] mul_p
);
   generate
      if (ARCH == 0) begin : g_operator
         assign mul_p = PROD_W'(mul_x) * PROD_W'(mul_y);
      end else begin : g_shift_add
         always_comb begin
            mul_p = '0;
            for (int i = 0; i < HALF_W; i++) begin
               if (mul_y[i]) mul_p = mul_p + (PROD_W'(mul_x) << i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
   import wide_mul_seq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   output logic  load,
   output logic  step,
   output pass_e pass,
   output logic  busy,
   output logic  done
);
   logic  busy_q, done_q;
   pass_e pass_q;

   assign load = start && !busy_q;
   assign step = busy_q;
   assign pass = pass_q;
   assign busy = busy_q;
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         pass_q <= PASS_LL;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            busy_q <= 1'b1;
            pass_q <= PASS_LL;
         end else if (busy_q) begin
            if (pass_q == PASS_HL) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               pass_q <= pass_e'(pass_q + 2'd1);
            end
         end
      end
   end
endmodule

// File: rtl/mul_seq_accum.sv
module mul_seq_accum
   import wide_mul_seq_pkg::*;
#(
   parameter int HALF_W = 8,
   localparam int PROD_W = 2 * HALF_W,
   localparam int RES_W  = 4 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  pass_e             pass,
   input  logic [PROD_W-1:0] prod,
   output logic [RES_W-1:0]  res,
   output logic              carry_top
);
   logic [HALF_W-1:0] byte_q [4];
   logic [HALF_W-1:0] p_lo, p_hi;
   logic [HALF_W:0]   sum1, sum2, sum3;

   assign p_lo = prod[HALF_W-1:0];
   assign p_hi = prod[PROD_W-1:HALF_W];

   always_comb begin
      sum1 = {1'b0, byte_q[1]} + {1'b0, p_lo};
      sum2 = {1'b0, byte_q[2]} + {1'b0, p_hi} + (HALF_W+1)'(sum1[HALF_W]);
      sum3 = {1'b0, byte_q[3]} + (HALF_W+1)'(sum2[HALF_W]);
   end

   assign carry_top = en && pass[1] && sum3[HALF_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) byte_q[k] <= '0;
      end else if (en) begin
         case (pass)
            PASS_LL: begin
               byte_q[0] <= p_lo;
               byte_q[1] <= p_hi;
            end
            PASS_HH: begin
               byte_q[2] <= p_lo;
               byte_q[3] <= p_hi;
            end
            default: begin
               byte_q[1] <= sum1[HALF_W-1:0];
               byte_q[2] <= sum2[HALF_W-1:0];
               byte_q[3] <= sum3[HALF_W-1:0];
            end
         endcase
      end
   end

   assign res = {byte_q[3], byte_q[2], byte_q[1], byte_q[0]};
endmodule

// File: rtl/wide_mul_seq.sv
module wide_mul_seq
   import wide_mul_seq_pkg::*;
#(
   parameter int HALF_W   = 8,
   parameter int MUL_ARCH = 0,
   localparam int OP_W  = 2 * HALF_W,
   localparam int RES_W = 4 * HALF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] result
);
   initial begin
      assert (HALF_W >= 2) else $error("HALF_W must be at least 2");
      assert (MUL_ARCH == 0 || MUL_ARCH == 1) else $error("MUL_ARCH must be 0 or 1");
   end

   logic            load, step, carry_top;
   pass_e           pass;
   logic [OP_W-1:0] a_q, b_q;
   logic [HALF_W-1:0] sel_x, sel_y;
   logic [OP_W-1:0] prod;

   mul_seq_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .step(step), .pass(pass),
      .busy(busy), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (load) begin
         a_q <= op_a;
         b_q <= op_b;
      end
   end

   always_comb begin
      sel_x = pass[0] ? a_q[OP_W-1:HALF_W] : a_q[HALF_W-1:0];
      case (pass)
         PASS_LL, PASS_HL: sel_y = b_q[HALF_W-1:0];
         default:          sel_y = b_q[OP_W-1:HALF_W];
      endcase
   end

   byte_mul #(.HALF_W(HALF_W), .ARCH(MUL_ARCH)) u_mul (
      .mul_x(sel_x), .mul_y(sel_y), .mul_p(prod)
   );

   mul_seq_accum #(.HALF_W(HALF_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(step), .pass(pass),
      .prod(prod), .res(result), .carry_top(carry_top)
   );
endmodule

// File: rtl/wide_mul_seq_chk.sv
module wide_mul_seq_chk #(
   parameter int HALF_W = 8,
   localparam int OP_W  = 2 * HALF_W,
   localparam int RES_W = 4 * HALF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [RES_W-1:0] result,
   input logic [OP_W-1:0]  a_q,
   input logic [OP_W-1:0]  b_q,
   input logic             carry_top
);
   logic [2:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               busy_cnt <= '0;
      else if (start && !busy)  busy_cnt <= '0;
      else if (busy)            busy_cnt <= busy_cnt + 3'd1;
   end

   assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> result == RES_W'(a_q) * RES_W'(b_q));
   assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);
   assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy_cnt == 3'd4);
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   assert_ops_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(a_q) && $stable(b_q));
   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(result));
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_top);
endmodule

bind wide_mul_seq wide_mul_seq_chk #(.HALF_W(HALF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .result(result), .a_q(a_q), .b_q(b_q), .carry_top(carry_top)
);

// File: tb/tb_wide_mul_seq.sv
module tb_wide_mul_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] op_a = '0, op_b = '0;
   logic        busy, done;
   logic [31:0] result;

   int n_cmp = 0, n_bad = 0;
   logic [31:0] exp_q [$];
   logic [31:0] last_exp;

   always #2 clk = ~clk;

   wide_mul_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .busy(busy), .done(done), .result(result)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // monitor: pops expected products as done pulses appear (R1)
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) check("R5 unexpected done", 32'd1, 32'd0);
         else check("R1 product", result, exp_q.pop_front());
      end
   end

   task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit disturb);
      int cyc;
      @(negedge clk);
      op_a = a; op_b = b; start = 1'b1;
      exp_q.push_back(32'(a) * 32'(b));
      last_exp = 32'(a) * 32'(b);
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after start", 32'(busy), 32'd1);
      cyc = 0;
      while (busy && cyc < 10) begin
         cyc++;
         if (disturb && cyc == 2) begin
            op_a = ~a; op_b = b ^ 16'h5a5a; start = 1'b1; // R4 and R5 stimulus
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check("R2 busy length", 32'(cyc), 32'd4);
      check("R3 done after busy", 32'(done), 32'd1);
      @(negedge clk);
      check("R3 done single cycle", 32'(done), 32'd0);
      check("R5 no restart", 32'(busy), 32'd0);
      check("R6 result held", result, last_exp);
      repeat (2) @(negedge clk);
      check("R6 result held idle", result, last_exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      check("R7 reset busy", 32'(busy), 32'd0);
      check("R7 reset done", 32'(done), 32'd0);
      check("R7 reset result", result, 32'd0);
      rst_n = 1'b1;
      run_op(16'h0000, 16'h0000, 1'b0);
      run_op(16'hffff, 16'hffff, 1'b0);          // R8 longest carry ripple
      check("R8 all-ones product", result, 32'hfffe0001);
      run_op(16'h00ff, 16'hff00, 1'b0);
      run_op(16'hff00, 16'h00ff, 1'b0);
      run_op(16'h1234, 16'h5678, 1'b1);          // R4 R5 disturbed run
      run_op(16'h8000, 16'h0002, 1'b0);
      run_op(16'h0001, 16'hffff, 1'b1);
      run_op(16'hff01, 16'h01ff, 1'b0);
      lfsr = 32'hace1_2468;
      for (int i = 0; i < 24; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         run_op(lfsr[15:0], lfsr[31:16] ^ 16'(i * 16'h1357), (i % 3) == 0);
      end
      repeat (3) @(negedge clk);
      check("R1 queue drained", 32'(exp_q.size()), 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule